// File: doc/BRIEF.md
# Bit-Sliced Arithmetic Logic Unit with Operand Gating

This block is a purely combinational arithmetic logic unit. It is built from a row of identical one-bit cells, and a ripple carry links each cell to the next. A two-bit operation code is expanded into four one-hot select lines. These lines pick one of four functions: bitwise AND, bitwise OR, inversion of the second operand, or addition with carry.

Each operand has its own enable input. When an enable is low, that operand reaches every cell as zero. A separate increment input is wired to the carry-in of bit 0. With the second operand gated off and increment high, the adder returns the first operand plus one, so no constant register is needed.

Because the block has no storage, it has no clock or reset. It is meant to be placed inside a datapath that registers the result elsewhere.

Top module: `alu8_sliced`

## Requirements
- R1: Operation code 2'b00 returns the bitwise AND of the two gated operands on `result`.
- R2: Operation code 2'b01 returns the bitwise OR of the two gated operands on `result`.
- R3: Operation code 2'b10 returns the bitwise inverse of the gated second operand on `result`; the first operand has no effect.
- R4: Operation code 2'b11 returns the sum of the gated first operand, the gated second operand and `inc_in`. The low 8 bits of that sum appear on `result` and bit 8 appears on `carry_out`.
- R5: For operation codes 00, 01 and 10, `carry_out` is 0.
- R6: When `b_en` is 0, the second operand is treated as zero by every operation; for example, code 10 then yields 8'hFF.
- R7: When `a_en` is 0, the first operand is treated as zero by every operation.
- R8: With `b_en` at 0, `inc_in` at 1 and code 11, `{carry_out,result}` equals the first operand plus one; an operand of 8'hFF yields 0 with `carry_out` at 1.
- R9: `inc_in` has no effect on `result` or `carry_out` for the three logic operations.
- R10: The carry ripples across all eight bits: 8'hFF plus 8'h01 yields 8'h00 with `carry_out` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | 8 | First operand |
| b_in | input | 8 | Second operand |
| fn_code | input | 2 | Operation code: 00 AND, 01 OR, 10 invert B, 11 add |
| a_en | input | 1 | High passes the first operand; low forces it to zero |
| b_en | input | 1 | High passes the second operand; low forces it to zero |
| inc_in | input | 1 | Carry-in of bit 0 |
| result | output | 8 | Result of the operation |
| carry_out | output | 1 | Carry out of bit 7 during addition; 0 otherwise |

## Verification
Operand gating and the carry-in of bit 0 can both act on one evaluation. The bench provokes this by driving a low enable together with a high increment under every operation code. A gated-off second operand with increment high must give the first operand plus one under addition. Under the logic codes, the same input combination must leave the result unchanged by the increment and must keep the carry at zero. Each input vector, whether from the corner list or random, is judged against a behavioural integer model in the clock phase after it is applied.

// File: rtl/alu_slice_pkg.sv
// Package alu_slice_pkg
// Holds the shared widths and the operation encoding used by the sliced ALU.
// Assumes the four-operation set; the select vector is indexed by the enum value.
package alu_slice_pkg;
    localparam int FN_W   = 2;
    localparam int N_OPS  = 1 << FN_W;

    typedef enum logic [FN_W-1:0] {
        OP_AND  = 2'b00,
        OP_OR   = 2'b01,
        OP_NOTB = 2'b10,
        OP_ADD  = 2'b11
    } alu_op_e;
endpackage

// File: rtl/alu_op_decode.sv
// Module alu_op_decode
// Expands the operation code into one select line per operation.
// Assumes every code value maps to an operation, so exactly one line is high.
module alu_op_decode
    import alu_slice_pkg::*;
(
    input  logic [FN_W-1:0]  code,
    output logic [N_OPS-1:0] sel
);
    // One-hot expansion of the operation code
    always_comb begin
        for (int i = 0; i < N_OPS; i++) begin
            sel[i] = (code == FN_W'(i));
        end
    end
endmodule

// File: rtl/alu_operand_gate.sv
// Module alu_operand_gate
// Passes an operand unchanged when enabled and presents zero when disabled.
// Assumes the enable is a static level during the evaluation.
module alu_operand_gate #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] din,
    input  logic             en,
    output logic [WIDTH-1:0] dout
);
    // AND every bit with the enable
    always_comb begin
        dout = din & {WIDTH{en}};
    end
endmodule

// File: rtl/alu_bit_slice.sv
// Module alu_bit_slice
// One bit of the ALU: logic functions and a full adder, chosen by one-hot selects.
// Assumes sel is one-hot; the carry-out is forced low unless addition is selected.
module alu_bit_slice
    import alu_slice_pkg::*;
(
    input  logic             a,
    input  logic             b,
    input  logic             cin,
    input  logic [N_OPS-1:0] sel,
    output logic             y,
    output logic             cout
);
    logic sum_bit;
    logic maj_bit;

    // Full-adder terms
    always_comb begin
        sum_bit = a ^ b ^ cin;
        maj_bit = (a & b) | (a & cin) | (b & cin);
    end

    // Select the output bit and qualify the carry
    always_comb begin
        y = (sel[OP_AND]  & (a & b))
          | (sel[OP_OR]   & (a | b))
          | (sel[OP_NOTB] & ~b)
          | (sel[OP_ADD]  & sum_bit);
        cout = sel[OP_ADD] & maj_bit;
    end
endmodule

// File: rtl/alu8_sliced.sv
// Module alu8_sliced
// Top of the ripple-carry ALU: operand gating, operation decode, and a chain
// of identical one-bit slices. Purely combinational; no clock and no state.
// Assumes the caller registers the outputs if timing needs it.
module alu8_sliced
    import alu_slice_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic [1:0]       fn_code,
    input  logic             a_en,
    input  logic             b_en,
    input  logic             inc_in,
    output logic [WIDTH-1:0] result,
    output logic             carry_out
);
    localparam int CHAIN_W = WIDTH + 1;

    logic [WIDTH-1:0]   a_gated;
    logic [WIDTH-1:0]   b_gated;
    logic [N_OPS-1:0]   sel_vec;
    logic [CHAIN_W-1:0] carry_chain;

    alu_operand_gate #(.WIDTH(WIDTH)) u_gate_a (.din(a_in), .en(a_en), .dout(a_gated));
    alu_operand_gate #(.WIDTH(WIDTH)) u_gate_b (.din(b_in), .en(b_en), .dout(b_gated));

    alu_op_decode u_decode (.code(fn_code), .sel(sel_vec));

    // Increment input enters the bottom of the chain
    always_comb begin
        carry_chain[0] = inc_in;
    end

    generate
        for (genvar g = 0; g < WIDTH; g++) begin : g_slice
            alu_bit_slice u_slice (
                .a    (a_gated[g]),
                .b    (b_gated[g]),
                .cin  (carry_chain[g]),
                .sel  (sel_vec),
                .y    (result[g]),
                .cout (carry_chain[g+1])
            );
        end
    endgenerate

    // Carry leaving the top slice
    always_comb begin
        carry_out = carry_chain[WIDTH];
    end
endmodule

// File: rtl/alu8_sliced_checker.sv
// Module alu8_sliced_checker
// Immediate assertions on the combinational ALU, bound to every instance.
// Assumes the settled values are seen once the combinational logic is ordered.
module alu8_sliced_checker #(
    parameter int WIDTH = 8
) (
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] b_in,
    input logic [1:0]       fn_code,
    input logic             a_en,
    input logic             b_en,
    input logic             inc_in,
    input logic [WIDTH-1:0] result,
    input logic             carry_out,
    input logic [3:0]       sel_vec
);
    logic [WIDTH-1:0] a_eff;
    logic [WIDTH-1:0] b_eff;
    logic [WIDTH:0]   sum_exp;

    // Independent view of the effective operands and the expected sum
    always_comb begin
        a_eff   = a_en ? a_in : '0;
        b_eff   = b_en ? b_in : '0;
        sum_exp = {1'b0, a_eff} + {1'b0, b_eff} + {{WIDTH{1'b0}}, inc_in};
    end

    // Property checks on the settled outputs
    always_comb begin
        p_sel_onehot_r1: assert ($onehot(sel_vec));
        if (fn_code != 2'b11) begin
            p_logic_carry_zero_r5: assert (carry_out == 1'b0);
        end
        if (fn_code == 2'b11) begin
            p_add_sum_r4: assert ({carry_out, result} == sum_exp);
        end
        if (fn_code == 2'b10 && !b_en) begin
            p_notb_gated_r6: assert (result == {WIDTH{1'b1}});
        end
        if (fn_code == 2'b00 && !a_en) begin
            p_and_gated_r7: assert (result == '0);
        end
        if (fn_code == 2'b01 && !a_en && !b_en) begin
            p_or_gated_r7: assert (result == '0);
        end
    end
endmodule

bind alu8_sliced alu8_sliced_checker #(.WIDTH(WIDTH)) u_chk (
    .a_in      (a_in),
    .b_in      (b_in),
    .fn_code   (fn_code),
    .a_en      (a_en),
    .b_en      (b_en),
    .inc_in    (inc_in),
    .result    (result),
    .carry_out (carry_out),
    .sel_vec   (sel_vec)
);

// File: tb/alu8_sliced_bench.sv
module alu8_sliced_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] a_in = '0;
    logic [7:0] b_in = '0;
    logic [1:0] fn_code = '0;
    logic       a_en = 1'b0;
    logic       b_en = 1'b0;
    logic       inc_in = 1'b0;
    logic [7:0] result;
    logic       carry_out;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    alu8_sliced u_alu8_sliced (
        .a_in(a_in), .b_in(b_in), .fn_code(fn_code), .a_en(a_en),
        .b_en(b_en), .inc_in(inc_in), .result(result), .carry_out(carry_out)
    );

    // Behavioural reference: returns {carry, result}
    function automatic logic [8:0] model(input int a, input int b, input int f,
                                         input bit ea, input bit eb, input bit ci);
        int x = ea ? a : 0;
        int y = eb ? b : 0;
        int r;
        case (f)
            0: r = x & y;
            1: r = x | y;
            2: r = (~y) & 255;
            default: r = x + y + int'(ci);
        endcase
        return 9'(r);
    endfunction

    function automatic string op_tag(input int f);
        case (f)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            default: return "R4";
        endcase
    endfunction

    // Apply one vector at a rising edge and judge it on the falling edge
    task automatic apply(input logic [7:0] a, input logic [7:0] b, input logic [1:0] f,
                         input bit ea, input bit eb, input bit ci, input string tag);
        logic [8:0] exp;
        @(posedge clk);
        a_in = a; b_in = b; fn_code = f; a_en = ea; b_en = eb; inc_in = ci;
        exp = model(int'(a), int'(b), int'(f), ea, eb, ci);
        @(negedge clk);
        n_checks++;
        if ({carry_out, result} !== exp) begin
            n_errors++;
            $display("FAIL %s: a=%h b=%h f=%0d ea=%0b eb=%0b inc=%0b got {c,y}=%h exp=%h",
                     tag, a, b, f, ea, eb, ci, {carry_out, result}, exp);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Idle state: all inputs low selects AND of zeros (R1, R5)
        n_checks++;
        if ({carry_out, result} !== 9'h000) begin
            n_errors++;
            $display("FAIL R1: idle got %h exp %h", {carry_out, result}, 9'h000);
        end
        apply(8'hF0, 8'h3C, 2'b00, 1, 1, 0, "R1");
        apply(8'hA5, 8'h0F, 2'b01, 1, 1, 0, "R2");
        apply(8'h5A, 8'h0F, 2'b10, 1, 1, 0, "R3");
        apply(8'h00, 8'h0F, 2'b10, 1, 1, 0, "R3");
        apply(8'h37, 8'h48, 2'b11, 1, 1, 0, "R4");
        apply(8'h80, 8'h80, 2'b11, 1, 1, 1, "R4");
        apply(8'hFF, 8'hFF, 2'b00, 1, 1, 1, "R5");
        apply(8'hFF, 8'hFF, 2'b01, 1, 1, 1, "R5");
        apply(8'h12, 8'h34, 2'b10, 1, 0, 0, "R6");
        apply(8'hFF, 8'hFF, 2'b00, 1, 0, 0, "R6");
        apply(8'hC3, 8'hFF, 2'b11, 1, 0, 0, "R6");
        apply(8'hFF, 8'hAA, 2'b01, 0, 1, 0, "R7");
        apply(8'hFF, 8'hFF, 2'b00, 0, 1, 0, "R7");
        apply(8'hFF, 8'h21, 2'b11, 0, 1, 0, "R7");
        apply(8'h41, 8'h99, 2'b11, 1, 0, 1, "R8");
        apply(8'hFF, 8'h99, 2'b11, 1, 0, 1, "R8");
        apply(8'h00, 8'h00, 2'b11, 1, 0, 1, "R8");
        apply(8'h0F, 8'hF0, 2'b00, 1, 1, 1, "R9");
        apply(8'h00, 8'h00, 2'b01, 1, 0, 1, "R9");
        apply(8'h77, 8'h88, 2'b10, 1, 1, 1, "R9");
        apply(8'hFF, 8'h01, 2'b11, 1, 1, 0, "R10");
        apply(8'h7F, 8'h00, 2'b11, 1, 1, 1, "R10");
        // Random sweep across every code and enable/increment combination
        for (int i = 0; i < 2000; i++) begin
            logic [1:0] f = 2'($urandom_range(0, 3));
            apply(8'($urandom), 8'($urandom), f, 1'($urandom), 1'($urandom),
                  1'($urandom), op_tag(int'(f)));
        end
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule